// File: doc/BRIEF.md
# Clock Distribution Divider Bank

This block is the digital back end of a clock synthesizer. It takes three source strobes that share one fabric clock: a crystal reference tick, a test-clock tick and a VCO tick. Each strobe is high for one fabric cycle per period of the clock it stands for. The block picks a reference with a select input. A bypass input then chooses whether the VCO or that reference drives the dividers. Four output banks derive square waves from the chosen source, each bank with its own power-of-two ratio. Bank A has one output, bank B one, bank C two and bank D five.

A separate feedback divider turns the VCO strobe into the slow comparison clock that a phase detector would use. A global hold input releases all nine outputs to high impedance. Inside the fabric this appears as a registered drive-enable signal for the pad buffers. The oscillator, phase detector, loop filter and VCO lie outside the block.

All banks take their phase from one shared counter, so outputs with equal ratios are identical and every output is phase-related to the slowest. A change of ratio waits for the bank's counter to finish its longer cycle, so an output never gets a shortened phase.

Top module: `clkdiv_bank`

## Requirements
- R1: Bank C drives its two outputs and bank D its five outputs as identical copies of the bank's divided clock.
- R2: Bank A (select bit `div_sel[0]`) has a period of 2 source ticks when its bit is 0 and 4 when it is 1, with a high phase of exactly half the period.
- R3: Banks B, C and D (select bits `div_sel[1]`, `div_sel[2]`, `div_sel[3]`) each have a period of 4 source ticks when their own bit is 0 and 8 when it is 1, at 50% duty.
- R4: With `pll_en` low, `ref_sel` low makes `xtal_tick` the source and `ref_sel` high makes `tclk_tick` the source.
- R5: With `pll_en` high, `vco_tick` is the source whatever `ref_sel` is. With `pll_en` low, the chosen reference feeds the dividers directly.
- R6: The cycle after `hiz` is sampled high, `out_drive` is low (all nine outputs at high impedance). The cycle after it is sampled low outside reset, `out_drive` is high. The dividers and `fb_clk` keep running while outputs are released.
- R7: `fb_clk` has a period of 8 `vco_tick` strobes when `fb_sel` is high and 16 when it is low, at 50% duty. It changes only in the cycle after a VCO strobe.
- R8: A bank output changes only in the cycle after a strobe of the currently selected source.
- R9: When bank D's output falls, bank A's output is low in that same cycle.
- R10: A bank samples its select bit only when the shared count completes the bank's longer ratio, and loads it directly during reset. A change made mid-cycle leaves the running cycle at the old ratio.
- R11: A synchronous active-high reset clears the counters and sets every bank output, `fb_clk` and `out_drive` low in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal reference period |
| tclk_tick | input | 1 | One-cycle strobe per test clock period |
| vco_tick | input | 1 | One-cycle strobe per VCO period |
| ref_sel | input | 1 | 0 selects the crystal strobe, 1 the test strobe |
| pll_en | input | 1 | 1 uses the VCO strobe, 0 bypasses it with the reference |
| fb_sel | input | 1 | 1 gives feedback ratio 8, 0 gives 16 |
| hiz | input | 1 | 1 releases all bank outputs to high impedance |
| div_sel | input | 4 | Per-bank ratio select: bit0 A, bit1 B, bit2 C, bit3 D |
| out_a | output | 1 | Bank A clock |
| out_b | output | 1 | Bank B clock |
| out_c | output | C_W | Bank C clocks |
| out_d | output | D_W | Bank D clocks |
| fb_clk | output | 1 | Feedback comparison clock |
| out_drive | output | 1 | Pad drive enable for all bank outputs, low means high impedance |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a bank's cycle. Such a change must not take effect until the shared count wraps, but from outside the count can only be inferred. The stimulus runs bank D at its slow ratio with a strobe every cycle and waits for D's falling edge, which marks the count at zero. One cycle later it flips bank A's select, then compares bank A's next six samples against a sequence worked out by hand. That sequence tells a deferred switch apart from one that takes effect at once.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    SRC_XTAL,
    SRC_TCLK,
    SRC_VCO
  } src_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/src_mux.sv
module src_mux
  import clkdiv_pkg::*;
(
  input  logic xtal_tick,
  input  logic tclk_tick,
  input  logic vco_tick,
  input  logic ref_sel,
  input  logic pll_en,
  output logic src_tick
);

  src_e which;

  always_comb begin
    if (pll_en)       which = SRC_VCO;
    else if (ref_sel) which = SRC_TCLK;
    else              which = SRC_XTAL;

    case (which)
      SRC_VCO:  src_tick = vco_tick;
      SRC_TCLK: src_tick = tclk_tick;
      default:  src_tick = xtal_tick;
    endcase
  end

endmodule

// File: rtl/phase_cnt.sv
module phase_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/bank_div.sv
module bank_div #(
  parameter int LO = 1,
  parameter int HI = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [HI-1:0] cnt,
  input  logic          sel,
  output logic          q
);

  localparam int IW = (HI > 1) ? $clog2(HI) : 1;
  localparam logic [IW-1:0] IDX_LO = IW'(LO - 1);
  localparam logic [IW-1:0] IDX_HI = IW'(HI - 1);

  logic [HI-1:0] nxt;
  logic          term;
  logic          sel_q;
  logic          sel_use;
  logic [IW-1:0] idx;

  always_comb begin
    nxt     = cnt + 1'b1;
    term    = &cnt;
    sel_use = term ? sel : sel_q;
    idx     = sel_use ? IDX_HI : IDX_LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel;
      q     <= 1'b0;
    end else if (tick) begin
      q <= nxt[idx];
      if (term) sel_q <= sel;
    end
  end

endmodule

// File: rtl/fb_div.sv
module fb_div #(
  parameter int LO = 3,
  parameter int HI = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic vco_tick,
  input  logic div_short,
  output logic fb
);

  logic [HI-1:0] fb_cnt;

  phase_cnt #(.W(HI)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (vco_tick),
    .cnt  (fb_cnt)
  );

  bank_div #(.LO(LO), .HI(HI)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (vco_tick),
    .cnt  (fb_cnt),
    .sel  (!div_short),
    .q    (fb)
  );

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int C_W    = 2,
  parameter int D_W    = 5,
  parameter int A_LO   = 1,
  parameter int A_HI   = 2,
  parameter int BCD_LO = 2,
  parameter int BCD_HI = 3,
  parameter int FB_LO  = 3,
  parameter int FB_HI  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xtal_tick,
  input  logic           tclk_tick,
  input  logic           vco_tick,
  input  logic           ref_sel,
  input  logic           pll_en,
  input  logic           fb_sel,
  input  logic           hiz,
  input  logic [3:0]     div_sel,
  output logic           out_a,
  output logic           out_b,
  output logic [C_W-1:0] out_c,
  output logic [D_W-1:0] out_d,
  output logic           fb_clk,
  output logic           out_drive
);

  localparam int NBANK = 4;
  localparam int CNT_W = imax(A_HI, BCD_HI);

  logic             src_tick;
  logic [CNT_W-1:0] phase;
  logic [NBANK-1:0] bank_q;

  src_mux u_src (
    .xtal_tick (xtal_tick),
    .tclk_tick (tclk_tick),
    .vco_tick  (vco_tick),
    .ref_sel   (ref_sel),
    .pll_en    (pll_en),
    .src_tick  (src_tick)
  );

  phase_cnt #(.W(CNT_W)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .tick (src_tick),
    .cnt  (phase)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO_B = (b == 0) ? A_LO : BCD_LO;
    localparam int HI_B = (b == 0) ? A_HI : BCD_HI;

    bank_div #(.LO(LO_B), .HI(HI_B)) u_div (
      .clk  (clk),
      .rst  (rst),
      .tick (src_tick),
      .cnt  (phase[HI_B-1:0]),
      .sel  (div_sel[b]),
      .q    (bank_q[b])
    );
  end

  fb_div #(.LO(FB_LO), .HI(FB_HI)) u_fb (
    .clk       (clk),
    .rst       (rst),
    .vco_tick  (vco_tick),
    .div_short (fb_sel),
    .fb        (fb_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) out_drive <= 1'b0;
    else     out_drive <= !hiz;
  end

  assign out_a = bank_q[0];
  assign out_b = bank_q[1];
  assign out_c = {C_W{bank_q[2]}};
  assign out_d = {D_W{bank_q[3]}};

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int C_W = 2,
  parameter int D_W = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           xtal_tick,
  input logic           tclk_tick,
  input logic           vco_tick,
  input logic           ref_sel,
  input logic           pll_en,
  input logic           hiz,
  input logic           out_a,
  input logic           out_b,
  input logic [C_W-1:0] out_c,
  input logic [D_W-1:0] out_d,
  input logic           fb_clk,
  input logic           out_drive
);

  logic any_src;
  always_comb any_src = pll_en ? vco_tick : (ref_sel ? tclk_tick : xtal_tick);

  // R1
  copies_match_chk: assert property (@(posedge clk) disable iff (rst)
    (out_c == {C_W{out_c[0]}}) && (out_d == {D_W{out_d[0]}}));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hiz) |-> !out_drive);

  // R6
  drive_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(hiz) && !$past(rst) |-> out_drive);

  // R7
  fb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(vco_tick) |-> $stable(fb_clk));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(any_src) |-> $stable(out_a) && $stable(out_b) && $stable(out_d[0]));

  // R9
  fall_align_chk: assert property (@(posedge clk) disable iff (rst)
    $past(out_d[0]) && !out_d[0] |-> !out_a);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b && out_c == '0 && out_d == '0 && !fb_clk && !out_drive));

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.C_W(C_W), .D_W(D_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .xtal_tick (xtal_tick),
  .tclk_tick (tclk_tick),
  .vco_tick  (vco_tick),
  .ref_sel   (ref_sel),
  .pll_en    (pll_en),
  .hiz       (hiz),
  .out_a     (out_a),
  .out_b     (out_b),
  .out_c     (out_c),
  .out_d     (out_d),
  .fb_clk    (fb_clk),
  .out_drive (out_drive)
);

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
  timeunit 1ns;
  timeprecision 1ps;

  // 50 MHz fabric clock
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       xtal_tick = 1'b0, tclk_tick = 1'b0, vco_tick = 1'b0;
  logic       ref_sel = 1'b0, pll_en = 1'b1, fb_sel = 1'b1, hiz = 1'b0;
  logic [3:0] div_sel = 4'b0000;
  logic       out_a, out_b, fb_clk, out_drive;
  logic [1:0] out_c;
  logic [4:0] out_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  clkdiv_bank i_clkdiv_bank (
    .clk, .rst, .xtal_tick, .tclk_tick, .vco_tick, .ref_sel, .pll_en,
    .fb_sel, .hiz, .div_sel, .out_a, .out_b, .out_c, .out_d, .fb_clk, .out_drive
  );

  // strobes: VCO every cycle, crystal every 2nd, test clock every 3rd
  int ph = 0;
  initial forever begin
    @(negedge clk);
    ph++;
    vco_tick  = 1'b1;
    xtal_tick = (ph % 2 == 0);
    tclk_tick = (ph % 3 == 0);
  end

  // {ref_sel, pll_en, fb_sel, div_sel[3:0]}
  localparam logic [6:0] VEC [8] = '{
    7'b0_1_1_0000, 7'b0_1_0_1111, 7'b0_0_1_0101, 7'b1_0_0_1010,
    7'b1_1_1_0011, 7'b0_0_0_1100, 7'b1_0_1_0110, 7'b1_0_0_1001
  };

  int per [10];
  int hi  [10];
  int lst [10];
  int run [10];

  task automatic sample();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [9:0] obs();
    return {fb_clk, out_d, out_c, out_b, out_a};
  endfunction

  task automatic measure(input int n);
    logic [9:0] prev, cur;
    for (int i = 0; i < 10; i++) begin
      per[i] = 0; hi[i] = 0; lst[i] = -1; run[i] = 0;
    end
    prev = obs();
    for (int t = 0; t < n; t++) begin
      sample();
      cur = obs();
      for (int i = 0; i < 10; i++) begin
        if (cur[i]) run[i]++;
        if (cur[i] && !prev[i]) begin
          if (lst[i] >= 0) per[i] = t - lst[i];
          lst[i] = t;
        end
        if (!cur[i] && prev[i]) begin
          hi[i] = run[i];
          run[i] = 0;
        end
      end
      prev = cur;
    end
  endtask

  task automatic scan(input int n, input string tag);
    logic [9:0] prev, cur;
    int bad1, bad8, bad9;
    logic src;
    bad1 = 0; bad8 = 0; bad9 = 0;
    prev = obs();
    for (int t = 0; t < n; t++) begin
      sample();
      cur = obs();
      src = pll_en ? vco_tick : (ref_sel ? tclk_tick : xtal_tick);
      if (out_c != {2{out_c[0]}} || out_d != {5{out_d[0]}}) bad1++;
      if (cur[8:0] != prev[8:0] && !src) bad8++;
      if (prev[4] && !cur[4] && cur[0]) bad9++;
      prev = cur;
    end
    check({"R1 copies ", tag}, bad1, 0);
    check({"R8 change without strobe ", tag}, bad8, 0);
    check({"R9 fall alignment ", tag}, bad9, 0);
  endtask

  task automatic check_reset_state(input string tag);
    check({"R11 out_a ", tag}, int'(out_a), 0);
    check({"R11 out_b ", tag}, int'(out_b), 0);
    check({"R11 out_c ", tag}, int'(out_c), 0);
    check({"R11 out_d ", tag}, int'(out_d), 0);
    check({"R11 fb_clk ", tag}, int'(fb_clk), 0);
    check({"R11 out_drive ", tag}, int'(out_drive), 0);
  endtask

  initial begin
    int stride, expd;
    int rat [10];
    logic prevd;
    int guard;

    // reset state
    repeat (3) sample();
    check_reset_state("power-up");
    rst = 1'b0;

    // vector walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      {ref_sel, pll_en, fb_sel, div_sel} = VEC[v];
      stride = pll_en ? 1 : (ref_sel ? 3 : 2);
      rat[0] = div_sel[0] ? 4 : 2;
      rat[1] = div_sel[1] ? 8 : 4;
      for (int i = 2; i < 4; i++) rat[i] = div_sel[2] ? 8 : 4;
      for (int i = 4; i < 9; i++) rat[i] = div_sel[3] ? 8 : 4;
      repeat (60) sample();
      measure(150);
      for (int i = 0; i < 10; i++) begin
        expd = (i == 9) ? (fb_sel ? 8 : 16) : rat[i] * stride;
        check($sformatf("%s R4/R5 vec%0d sig%0d period", (i == 9) ? "R7" : (i == 0 ? "R2" : "R3"), v, i),
              per[i], expd);
        check($sformatf("%s vec%0d sig%0d high phase", (i == 9) ? "R7" : (i == 0 ? "R2" : "R3"), v, i),
              hi[i], expd / 2);
      end
    end

    // copies, strobe gating, fall alignment under two reference modes
    {ref_sel, pll_en, fb_sel, div_sel} = VEC[3];
    repeat (30) sample();
    scan(120, "tclk");
    {ref_sel, pll_en, fb_sel, div_sel} = VEC[2];
    repeat (30) sample();
    scan(120, "xtal");

    // R6 release: outputs disabled, dividers keep running
    {ref_sel, pll_en, fb_sel, div_sel} = 7'b0_1_1_0000;
    repeat (30) sample();
    hiz = 1'b1;
    sample();
    sample();
    check("R6 drive released", int'(out_drive), 0);
    measure(80);
    check("R6 bank A runs while released", per[0], 2);
    check("R6 fb_clk runs while released", per[9], 8);
    hiz = 1'b0;
    sample();
    sample();
    check("R6 drive restored", int'(out_drive), 1);

    // R10 mid-cycle ratio change on bank A
    div_sel = 4'b1000;
    repeat (40) sample();
    prevd = out_d[0];
    guard = 0;
    sample();
    while (!(prevd && !out_d[0]) && guard < 100) begin
      prevd = out_d[0];
      sample();
      guard++;
    end
    check("R10 sync found", int'(guard < 100), 1);
    sample();
    check("R10 count1 out_a", int'(out_a), 1);
    div_sel[0] = 1'b1;
    begin
      int seq [6] = '{0, 1, 0, 0, 1, 1};
      for (int k = 0; k < 6; k++) begin
        sample();
        check($sformatf("R10 step%0d out_a", k), int'(out_a), seq[k]);
      end
    end

    // R11 reset during operation
    rst = 1'b1;
    sample();
    check_reset_state("mid-run");
    rst = 1'b0;
    sample();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule